// File: doc/BRIEF.md
# Debug Occurrence Status Register

This block records, for an on-chip debug controller, why the processor last entered debug mode, and it follows a two-step chained breakpoint sequence. The core and the debug logic send single-cycle event strobes: a breakpoint instruction executed, the trace counter reaching zero, a FIFO freeze, memory breakpoint A or B matching, debug entry, and debug exit with its two command bits. Each cause is kept as a sticky flag. The flags clear only on test-logic reset or on a debug exit that carries both command bits.

When chaining is on, a breakpoint A match arms breakpoint B. A later breakpoint B match then enables the trace counter. The block also keeps a registered 2-bit copy of the processor's operating mode. It presents the flags and the mode as individual outputs and as one parallel status word.

Top module: `dbg_occur_status`

## Requirements
- R1: The software-breakpoint flag sets on a cycle where debug entry and breakpoint-instruction are both high. A breakpoint-instruction strobe without debug entry does not set it.
- R2: The trace-count flag sets on a cycle where debug entry, trace enable and trace-zero are all high. It does not set when trace enable is low.
- R3: The FIFO-freeze flag sets on any cycle with the freeze strobe high.
- R4: With chaining on, a breakpoint A match sets the A-arm flag, and `bpb_enable_o` goes high from the next cycle.
- R5: With chaining on, a breakpoint B match sets the B-arm flag, and `trc_cnt_enable_o` goes high, only if the A-arm flag is already set. A B match in the same cycle as the arming A match is ignored.
- R6: With chaining off, neither arm flag sets, whatever the breakpoint matches do.
- R7: All five flags clear after a cycle with debug exit, go and exit-command all high, and while `tl_rst_n` is low.
- R8: A debug exit that lacks go or lacks exit-command leaves every flag unchanged.
- R9: When a valid clear and a set event fall in the same cycle, the clear wins and the flag reads 0.
- R10: `mode_o` is registered from the core mode inputs with one cycle of latency. Halt gives 2'b10 and has priority over low-power, which gives 2'b01. Neither input gives 2'b00. The code 2'b11 is never produced.
- R11: `status_o` bit 6 holds the software flag, bit 5 the trace-count flag, bit 4 the FIFO-freeze flag, bit 3 the B-arm flag and bit 2 the A-arm flag. Bits 1:0 hold the mode.
- R12: A set flag stays set on later cycles without events until a valid clear or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| tl_rst_n | input | 1 | Test-logic reset, active low, asynchronous |
| bkpt_exec_i | input | 1 | Breakpoint instruction executed |
| dbg_entry_i | input | 1 | Processor entering debug mode |
| trace_on_i | input | 1 | Trace mode enabled |
| trace_zero_i | input | 1 | Trace counter reached zero |
| fifo_frz_i | input | 1 | FIFO freeze event |
| seq_on_i | input | 1 | Chained breakpoint operation enabled |
| bpa_hit_i | input | 1 | Memory breakpoint A match |
| bpb_hit_i | input | 1 | Memory breakpoint B match |
| dbg_exit_i | input | 1 | Debug mode exit strobe |
| cmd_go_i | input | 1 | Go command bit of the exit |
| cmd_ex_i | input | 1 | Exit command bit of the exit |
| core_lowpwr_i | input | 1 | Core in stop, doze or wait |
| core_halt_i | input | 1 | Core in debug mode |
| sw_flag_o | output | 1 | Software-breakpoint flag |
| trc_flag_o | output | 1 | Trace-count flag |
| frz_flag_o | output | 1 | FIFO-freeze flag |
| armb_flag_o | output | 1 | B-arm flag |
| arma_flag_o | output | 1 | A-arm flag |
| mode_o | output | 2 | Registered processor mode |
| bpb_enable_o | output | 1 | Breakpoint B enabled |
| trc_cnt_enable_o | output | 1 | Trace counter enabled |
| status_o | output | 7 | Packed status word |

## Verification
The assertions treat every event input as a sampled level that the clock edge captures. They assume the strobes are already synchronous to `clk` and free of glitches. They also assume that the core never reports halt and low-power together without halt taking priority.

The stimulus changes every input only at the falling edge and holds it for a full cycle. It drives each combination, including overlapping set and clear strobes, as one clean cycle followed by an idle cycle or the next vector. Mode inputs are held for the whole cycle whose result is checked.

// File: rtl/dbg_occ_pkg.sv
package dbg_occ_pkg;
    localparam int MODE_W = 2;
    localparam int FLAG_N = 5;
    localparam int STAT_W = FLAG_N + MODE_W;

    // flag positions inside the flag vector (status word = {flags, mode})
    localparam int FL_ARMA = 0;
    localparam int FL_ARMB = 1;
    localparam int FL_FRZ  = 2;
    localparam int FL_TRC  = 3;
    localparam int FL_SW   = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN    = 2'b00,
        MODE_LOWPWR = 2'b01,
        MODE_DEBUG  = 2'b10,
        MODE_RSVD   = 2'b11
    } pmode_e;
endpackage

// File: rtl/dbg_seq_chain.sv
module dbg_seq_chain (
    input  logic seq_on_i,
    input  logic bpa_hit_i,
    input  logic bpb_hit_i,
    input  logic arma_q_i,
    input  logic armb_q_i,
    output logic set_arma_o,
    output logic set_armb_o,
    output logic bpb_en_o,
    output logic trc_en_o
);
    typedef struct packed {
        logic set_a;
        logic set_b;
    } chain_t;

    chain_t chain_d;

    always_comb begin
        chain_d       = '0;
        chain_d.set_a = seq_on_i & bpa_hit_i;
        // B only counts once A has been armed in an earlier cycle
        chain_d.set_b = seq_on_i & bpb_hit_i & arma_q_i;
    end

    assign set_arma_o = chain_d.set_a;
    assign set_armb_o = chain_d.set_b;
    assign bpb_en_o   = arma_q_i;
    assign trc_en_o   = armb_q_i;
endmodule

// File: rtl/dbg_flag_bank.sv
module dbg_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < N; i++) begin
            if (clr_i)
                bank_d.flags[i] = 1'b0;
            else if (set_i[i])
                bank_d.flags[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign flags_o = bank_q.flags;

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (flags_o == '0));

    // R12
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    generate
        for (genvar b = 0; b < N; b++) begin : g_bit
            // R3
            set_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (set_i[b] && !clr_i) |=> flags_o[b]);
        end
    endgenerate
endmodule

// File: rtl/dbg_mode_track.sv
module dbg_mode_track
    import dbg_occ_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   halt_i,
    input  logic   lowpwr_i,
    output pmode_e mode_o
);
    typedef struct packed {
        pmode_e mode;
    } mtrk_t;

    mtrk_t mtrk_d, mtrk_q;

    always_comb begin
        mtrk_d = mtrk_q;
        if (halt_i)        mtrk_d.mode = MODE_DEBUG;
        else if (lowpwr_i) mtrk_d.mode = MODE_LOWPWR;
        else               mtrk_d.mode = MODE_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mtrk_q <= '{mode: MODE_RUN};
        else        mtrk_q <= mtrk_d;
    end

    assign mode_o = mtrk_q.mode;

    // R10
    mode_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (mode_o == MODE_DEBUG));

    // R10
    mode_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpwr_i && !halt_i) |=> (mode_o == MODE_LOWPWR));
endmodule

// File: rtl/dbg_occur_status.sv
module dbg_occur_status
    import dbg_occ_pkg::*;
(
    input  logic              clk,
    input  logic              tl_rst_n,
    input  logic              bkpt_exec_i,
    input  logic              dbg_entry_i,
    input  logic              trace_on_i,
    input  logic              trace_zero_i,
    input  logic              fifo_frz_i,
    input  logic              seq_on_i,
    input  logic              bpa_hit_i,
    input  logic              bpb_hit_i,
    input  logic              dbg_exit_i,
    input  logic              cmd_go_i,
    input  logic              cmd_ex_i,
    input  logic              core_lowpwr_i,
    input  logic              core_halt_i,
    output logic              sw_flag_o,
    output logic              trc_flag_o,
    output logic              frz_flag_o,
    output logic              armb_flag_o,
    output logic              arma_flag_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              bpb_enable_o,
    output logic              trc_cnt_enable_o,
    output logic [STAT_W-1:0] status_o
);
    logic [FLAG_N-1:0] flags_q;
    logic [FLAG_N-1:0] set_d;
    logic              clr_d;
    logic              set_arma, set_armb;
    pmode_e            mode_q;

    dbg_seq_chain u_chain (
        .seq_on_i   (seq_on_i),
        .bpa_hit_i  (bpa_hit_i),
        .bpb_hit_i  (bpb_hit_i),
        .arma_q_i   (flags_q[FL_ARMA]),
        .armb_q_i   (flags_q[FL_ARMB]),
        .set_arma_o (set_arma),
        .set_armb_o (set_armb),
        .bpb_en_o   (bpb_enable_o),
        .trc_en_o   (trc_cnt_enable_o)
    );

    always_comb begin
        set_d          = '0;
        set_d[FL_SW]   = dbg_entry_i & bkpt_exec_i;
        set_d[FL_TRC]  = dbg_entry_i & trace_on_i & trace_zero_i;
        set_d[FL_FRZ]  = fifo_frz_i;
        set_d[FL_ARMB] = set_armb;
        set_d[FL_ARMA] = set_arma;
        clr_d          = dbg_exit_i & cmd_go_i & cmd_ex_i;
    end

    dbg_flag_bank #(.N(FLAG_N)) u_flags (
        .clk     (clk),
        .rst_n   (tl_rst_n),
        .set_i   (set_d),
        .clr_i   (clr_d),
        .flags_o (flags_q)
    );

    dbg_mode_track u_mode (
        .clk      (clk),
        .rst_n    (tl_rst_n),
        .halt_i   (core_halt_i),
        .lowpwr_i (core_lowpwr_i),
        .mode_o   (mode_q)
    );

    assign sw_flag_o   = flags_q[FL_SW];
    assign trc_flag_o  = flags_q[FL_TRC];
    assign frz_flag_o  = flags_q[FL_FRZ];
    assign armb_flag_o = flags_q[FL_ARMB];
    assign arma_flag_o = flags_q[FL_ARMA];
    assign mode_o      = mode_q;
    assign status_o    = {flags_q, mode_q};

    // R5
    armb_order_chk: assert property (@(posedge clk) disable iff (!tl_rst_n)
        $rose(armb_flag_o) |-> $past(arma_flag_o));

    // R6
    seq_off_chk: assert property (@(posedge clk) disable iff (!tl_rst_n)
        !seq_on_i |=> !$rose(arma_flag_o) && !$rose(armb_flag_o));

    // R8
    exit_partial_chk: assert property (@(posedge clk) disable iff (!tl_rst_n)
        (dbg_exit_i && !(cmd_go_i && cmd_ex_i)) |=>
            ((status_o[STAT_W-1:MODE_W] & $past(status_o[STAT_W-1:MODE_W]))
                == $past(status_o[STAT_W-1:MODE_W])));

    // R1
    sw_entry_chk: assert property (@(posedge clk) disable iff (!tl_rst_n)
        $rose(sw_flag_o) |-> $past(dbg_entry_i && bkpt_exec_i));
endmodule

// File: tb/dbg_occur_status_tb.sv
`timescale 1ns/1ps
module dbg_occur_status_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bkpt, entry, tron, trz, frz, seq, ahit, bhit, ext, go, ex, lp, halt;
    logic sw_f, trc_f, frz_f, armb_f, arma_f, bpb_en, trc_en;
    logic [1:0] mode;
    logic [6:0] status;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dbg_occur_status u_dut (
        .clk(clk), .tl_rst_n(rst_n), .bkpt_exec_i(bkpt), .dbg_entry_i(entry),
        .trace_on_i(tron), .trace_zero_i(trz), .fifo_frz_i(frz), .seq_on_i(seq),
        .bpa_hit_i(ahit), .bpb_hit_i(bhit), .dbg_exit_i(ext), .cmd_go_i(go),
        .cmd_ex_i(ex), .core_lowpwr_i(lp), .core_halt_i(halt),
        .sw_flag_o(sw_f), .trc_flag_o(trc_f), .frz_flag_o(frz_f),
        .armb_flag_o(armb_f), .arma_flag_o(arma_f), .mode_o(mode),
        .bpb_enable_o(bpb_en), .trc_cnt_enable_o(trc_en), .status_o(status)
    );

    // vector: {inputs[12:0], expected status[6:0], requirement[3:0]}
    // input order: bkpt entry tron trz frz seq ahit bhit exit go ex lowpwr halt
    localparam int NV = 18;
    localparam logic [23:0] VEC [NV] = '{
        {13'b0000100000000, 7'h10, 4'd3},   // R3 freeze sets
        {13'b0000000000000, 7'h10, 4'd12},  // R12 holds
        {13'b0000010100000, 7'h10, 4'd5},   // R5 B without A ignored
        {13'b0000011000000, 7'h14, 4'd4},   // R4 A arms
        {13'b0000010100000, 7'h1C, 4'd5},   // R5 B after A
        {13'b0000000011000, 7'h1C, 4'd8},   // R8 go only
        {13'b0000000010100, 7'h1C, 4'd8},   // R8 exit-cmd only
        {13'b0000000011100, 7'h00, 4'd7},   // R7 full clear
        {13'b0000001100000, 7'h00, 4'd6},   // R6 chaining off
        {13'b0000000000010, 7'h01, 4'd10},  // R10 low power
        {13'b0000000000011, 7'h02, 4'd10},  // R10 halt wins
        {13'b1100000000001, 7'h42, 4'd1},   // R1 bkpt entry
        {13'b0111000000001, 7'h62, 4'd2},   // R2 trace zero entry
        {13'b0000100011101, 7'h02, 4'd9},   // R9 clear beats freeze
        {13'b0101000000000, 7'h00, 4'd2},   // R2 trace off
        {13'b1000000000000, 7'h00, 4'd1},   // R1 no entry
        {13'b0000011100000, 7'h04, 4'd5},   // R5 same-cycle A and B
        {13'b0000000000000, 7'h04, 4'd12}   // R12 holds
    };

    task automatic drive(input logic [12:0] v);
        {bkpt, entry, tron, trz, frz, seq, ahit, bhit, ext, go, ex, lp, halt} = v;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [12:0] v);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        drive(13'b0);
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset", status, 7'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][23:11]);
            check($sformatf("R%0d vec%0d", VEC[i][3:0], i), status, VEC[i][10:4]);
        end

        // R11 individual outputs agree with word layout; arm A is set here
        check("R11 arma", arma_f, 1'b1);
        check("R4 bpb_enable", bpb_en, 1'b1);
        step(13'b0000010100000);
        check("R5 trc_cnt_enable", trc_en, 1'b1);
        step(13'b1100100000001);
        @(negedge clk);
        drive(13'b0);
        @(posedge clk);
        #1;
        check("R11 word", status, {sw_f, trc_f, frz_f, armb_f, arma_f, mode});
        check("R11 layout", status, 7'h5C);
        check("R10 mode back to run", mode, 2'b00);

        // R7 test-logic reset clears mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R7 async reset", status, 7'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step(13'b0);
        check("R7 after reset", status, 7'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule